// File: doc/BRIEF.md
# Interrupt Event Capture and Masking Bank

This block sits beside the engine of a serial bus controller and turns the engine's one-cycle event pulses into a single level-sensitive interrupt request. Each event source has a sticky status bit. The status bit latches the event whether or not the source is masked. Software clears a status bit by writing a one to its position. A common way to do this is to write back the value just read.

Masking works through two write-only ports. A one written to the unmask port lets that source through to the interrupt line. A one written to the mask port blocks it. The current mask can be read at its own offset. A second output flags when any unmasked error-class source is pending. All registers use one shared bit layout, so software can use the same pattern at every offset.

Top module: `irq_event_bank`

## Requirements
- R1: After reset, every status bit reads 0, the mask register (offset 0x20) reads 0x2FF with every valid source masked, and both outputs are low.
- R2: A pulse on an event input bit sets the matching status bit (offset 0x10) on the next clock edge, whether or not that source is masked. The bit then stays set until it is cleared. Bit positions are: 0 complete, 1 data threshold, 2 NACK, 3 timeout, 4 slave ready, 5 receive overflow, 6 transmit overflow, 7 receive underflow, 9 arbitration lost.
- R3: Writing a pattern to offset 0x10 clears exactly the status bits that are one in the pattern and leaves the other bits unchanged.
- R4: Writing a pattern to the unmask port (offset 0x24) clears those mask bits and leaves the other mask bits unchanged.
- R5: Writing a pattern to the mask port (offset 0x28) sets those mask bits. Writing 0x2FF there masks every source.
- R6: The interrupt output is high exactly when some status bit is set whose mask bit is clear.
- R7: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R8: The error output is high exactly when an unmasked status bit is set among NACK (bit 2), receive overflow (5), transmit overflow (6), receive underflow (7) and arbitration lost (9).
- R9: Bit 8 is reserved. It reads 0 in status and mask, and events or writes on it have no effect.
- R10: Reads of the two write-only ports (0x24, 0x28) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 10 | One-cycle event pulses from the controller engine, one bit per source |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 10 | Write data |
| reg_rdata | output | 10 | Read data for the current `reg_addr`, combinational |
| irq_o | output | 1 | Level interrupt request |
| err_o | output | 1 | Unmasked error-class event pending |

## Verification
The assertions assume the write strobe lasts one cycle and selects a single offset, so an unmask write and a mask write never occur in the same cycle. They also assume event pulses may arrive at any time, including in the same cycle as a write. The stimulus changes every input only at the falling clock edge. It issues one register write at a time and overlaps an event with a clearing write only in the scenario that tests which one takes priority.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int unsigned SRC_W = 10;

    localparam int unsigned B_DONE   = 0;
    localparam int unsigned B_THRESH = 1;
    localparam int unsigned B_NACK   = 2;
    localparam int unsigned B_TMO    = 3;
    localparam int unsigned B_SLVRDY = 4;
    localparam int unsigned B_RXOVR  = 5;
    localparam int unsigned B_TXOVR  = 6;
    localparam int unsigned B_RXUND  = 7;
    localparam int unsigned B_RSVD   = 8;
    localparam int unsigned B_ARBLST = 9;

    typedef logic [SRC_W-1:0] src_vec_t;

    localparam src_vec_t VALID_BITS = ~(src_vec_t'(1) << B_RSVD);

    localparam src_vec_t ERR_BITS = (src_vec_t'(1) << B_NACK)
                                  | (src_vec_t'(1) << B_RXOVR)
                                  | (src_vec_t'(1) << B_TXOVR)
                                  | (src_vec_t'(1) << B_RXUND)
                                  | (src_vec_t'(1) << B_ARBLST);

    typedef struct packed {
        src_vec_t bits;
    } vec_state_t;

endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg
    import irq_bank_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t set_i,
    input  src_vec_t clr_i,
    output src_vec_t status_o
);

    vec_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // clear first, then set: an event in the same cycle survives
        st_d.bits = ((st_q.bits & ~clr_i) | set_i) & VALID_BITS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.bits;

    AST_EVT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((status_o & $past(set_i)) == $past(set_i))); // R2

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i & clr_i) != '0) |=> ((status_o & $past(set_i & clr_i)) == $past(set_i & clr_i))); // R7

    AST_W1C_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((status_o & $past(clr_i & ~set_i)) == '0)); // R3

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0) |=> ((status_o & $past(status_o)) == $past(status_o))); // R2

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import irq_bank_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t unmask_i,
    input  src_vec_t mask_i,
    output src_vec_t mask_o
);

    vec_state_t mk_d, mk_q;

    always_comb begin
        mk_d = mk_q;
        mk_d.bits = ((mk_q.bits & ~unmask_i) | mask_i) & VALID_BITS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mk_q.bits <= VALID_BITS;
        else        mk_q      <= mk_d;
    end

    assign mask_o = mk_q.bits;

    AST_UNMASK_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        (unmask_i != '0 && mask_i == '0) |=> ((mask_o & $past(unmask_i)) == '0)); // R4

    AST_MASK_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i != '0) |=> ((mask_o & $past(mask_i & VALID_BITS)) == $past(mask_i & VALID_BITS))); // R5

    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (unmask_i == '0 && mask_i == '0) |=> $stable(mask_o)); // R4

endmodule

// File: rtl/irq_combine.sv
module irq_combine
    import irq_bank_pkg::*;
(
    input  src_vec_t status_i,
    input  src_vec_t mask_i,
    output logic     irq_o,
    output logic     err_o
);

    src_vec_t pending;

    for (genvar b = 0; b < SRC_W; b++) begin : g_pend
        assign pending[b] = status_i[b] & ~mask_i[b];
    end

    always_comb begin
        irq_o = |pending;
        err_o = |(pending & ERR_BITS);
    end

endmodule

// File: rtl/irq_event_bank.sv
module irq_event_bank
    import irq_bank_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned OFS_STATUS = 8'h10,
    parameter int unsigned OFS_MASK   = 8'h20,
    parameter int unsigned OFS_UNMASK = 8'h24,
    parameter int unsigned OFS_DOMASK = 8'h28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  evt_i,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [SRC_W-1:0]  reg_wdata,
    output logic [SRC_W-1:0]  reg_rdata,
    output logic              irq_o,
    output logic              err_o
);

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_UNMASK = ADDR_W'(OFS_UNMASK);
    localparam logic [ADDR_W-1:0] A_DOMASK = ADDR_W'(OFS_DOMASK);

    src_vec_t set_vec, clr_vec, unmask_vec, domask_vec;
    src_vec_t status_q, mask_q;

    always_comb begin
        set_vec    = evt_i & VALID_BITS;
        clr_vec    = '0;
        unmask_vec = '0;
        domask_vec = '0;
        if (reg_wr) begin
            unique case (reg_addr)
                A_STATUS: clr_vec    = reg_wdata & VALID_BITS;
                A_UNMASK: unmask_vec = reg_wdata & VALID_BITS;
                A_DOMASK: domask_vec = reg_wdata & VALID_BITS;
                default:  ;
            endcase
        end
    end

    irq_status_reg u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_vec),
        .clr_i    (clr_vec),
        .status_o (status_q)
    );

    irq_mask_reg u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .unmask_i (unmask_vec),
        .mask_i   (domask_vec),
        .mask_o   (mask_q)
    );

    irq_combine u_comb (
        .status_i (status_q),
        .mask_i   (mask_q),
        .irq_o    (irq_o),
        .err_o    (err_o)
    );

    always_comb begin
        unique case (reg_addr)
            A_STATUS: reg_rdata = status_q;
            A_MASK:   reg_rdata = mask_q;
            default:  reg_rdata = '0;
        endcase
    end

    AST_ERR_IMPLIES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> irq_o); // R8

    AST_EVT_UNMASKED_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_vec & ~mask_q & ~domask_vec) != '0) |=> irq_o); // R6

endmodule

// File: tb/sim_irq_event_bank.sv
module sim_irq_event_bank;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] evt_i = '0;
    logic [7:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [9:0] reg_wdata = '0;
    logic [9:0] reg_rdata;
    logic       irq_o, err_o;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [7:0] A_ST = 8'h10, A_MK = 8'h20, A_EN = 8'h24, A_DI = 8'h28;

    always #10 clk = ~clk;

    irq_event_bank u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o), .err_o(err_o)
    );

    task automatic check(input string tag, input logic [9:0] got, input logic [9:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [9:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse(input logic [9:0] e);
        @(negedge clk);
        evt_i = e;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [9:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic t_reset;
        logic [9:0] v;
        rd(A_ST, v); check("R1 status after reset", v, 10'h000);
        rd(A_MK, v); check("R1 mask after reset", v, 10'h2FF);
        check("R1 irq after reset", {9'b0, irq_o}, 10'h000);
        check("R1 err after reset", {9'b0, err_o}, 10'h000);
    endtask

    task automatic t_capture_masked;
        logic [9:0] v;
        pulse(10'h003);
        rd(A_ST, v); check("R2 capture while masked", v, 10'h003);
        check("R6 masked source keeps irq low", {9'b0, irq_o}, 10'h000);
        pulse(10'h000);
        rd(A_ST, v); check("R2 status sticky", v, 10'h003);
    endtask

    task automatic t_unmask;
        logic [9:0] v;
        wr(A_EN, 10'h001);
        rd(A_MK, v); check("R4 unmask one bit", v, 10'h2FE);
        check("R6 irq after unmask", {9'b0, irq_o}, 10'h001);
        check("R8 non-error source no err", {9'b0, err_o}, 10'h000);
    endtask

    task automatic t_w1c;
        logic [9:0] v;
        wr(A_ST, 10'h001);
        rd(A_ST, v); check("R3 w1c clears only written bit", v, 10'h002);
        check("R6 irq drops after clear", {9'b0, irq_o}, 10'h000);
    endtask

    task automatic t_error;
        logic [9:0] v;
        pulse(10'h004);
        check("R8 masked nack no err", {9'b0, err_o}, 10'h000);
        wr(A_EN, 10'h004);
        check("R8 err for unmasked nack", {9'b0, err_o}, 10'h001);
        check("R6 irq for unmasked nack", {9'b0, irq_o}, 10'h001);
        wr(A_DI, 10'h004);
        rd(A_MK, v); check("R5 remask nack", v, 10'h2FE);
        check("R5 err off after remask", {9'b0, err_o}, 10'h000);
    endtask

    task automatic t_set_wins;
        logic [9:0] v;
        // status currently 0x006; clear 0x006 while nack pulses again
        @(negedge clk);
        reg_addr = A_ST; reg_wdata = 10'h006; reg_wr = 1'b1; evt_i = 10'h004;
        @(negedge clk);
        reg_wr = 1'b0; evt_i = '0;
        rd(A_ST, v); check("R7 set wins over clear", v, 10'h004);
    endtask

    task automatic t_reserved;
        logic [9:0] v;
        pulse(10'h100);
        rd(A_ST, v); check("R9 reserved event ignored", v, 10'h004);
        wr(A_EN, 10'h100);
        rd(A_MK, v); check("R9 reserved mask bit reads 0", v, 10'h2FE);
        wr(A_ST, 10'h100);
        rd(A_ST, v); check("R9 reserved clear no effect", v, 10'h004);
    endtask

    task automatic t_mask_all;
        logic [9:0] v;
        pulse(10'h2E0);
        wr(A_EN, 10'h3FF);
        rd(A_MK, v); check("R4 unmask all", v, 10'h000);
        check("R8 err with all unmasked", {9'b0, err_o}, 10'h001);
        wr(A_DI, 10'h2FF);
        rd(A_MK, v); check("R5 mask all", v, 10'h2FF);
        check("R5 irq low with all masked", {9'b0, irq_o}, 10'h000);
        rd(A_ST, v); check("R2 status kept while masked", v, 10'h2E4);
    endtask

    task automatic t_wo_reads;
        logic [9:0] v;
        rd(A_EN, v); check("R10 unmask port reads 0", v, 10'h000);
        rd(A_DI, v); check("R10 mask port reads 0", v, 10'h000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_capture_masked();
        t_unmask();
        t_w1c();
        t_error();
        t_set_wins();
        t_reserved();
        t_mask_all();
        t_wo_reads();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired got=running exp=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule